// File: doc/BRIEF.md
# Quadrature Count-Interval Trigger Generator

This block turns the two phase lines of an incremental quadrature encoder into a 24-bit signed position count. Each phase line is sampled through a two-flop synchroniser. Every legal single-phase transition moves the count by one, and the phase relationship sets the direction. A step in which both phases change at once is rejected and latched in an error flag.

A reference register holds the count at the most recent trigger point. When the net travel from that reference reaches `STEP` counts in either direction, the block reloads the reference and drives an active-low pulse that lasts exactly `PULSE_CLKS` system clocks. The enable input gates the pulse only; the counter always keeps tracking the encoder. A trigger point that arrives while a pulse is already running is counted in a saturating missed-event counter and does not affect the running pulse. A counter-clear input returns the position and the reference to zero and cancels any pulse.

The system clock must be at least four times faster than the highest phase transition rate.

Top module: `qenc_step_trigger`

## Requirements
- R1: With the phases written as {enc_a, enc_b}, each transition forward along the cycle 00, 01, 11, 10, 00 adds one to `count`, and each transition in the reverse direction subtracts one.
- R2: A sampled step in which both phases change leaves `count` unchanged and sets `phase_err`. `phase_err` stays set until `rst_n` is asserted. The new phase pair becomes the base for the next step.
- R3: `count` is 24 bits and wraps modulo 2^24, so one step down from 0 gives 0xFFFFFF.
- R4: `trig_n` goes low when `count` has moved `STEP` counts up or down from the reference value. The reference is then reloaded with that count.
- R5: A pulse that is not interrupted keeps `trig_n` low for exactly `PULSE_CLKS` consecutive clocks.
- R6: A trigger point reached while a pulse is active neither restarts nor stretches that pulse. It increments `miss_cnt`, which holds at its all-ones value once it gets there.
- R7: While `en` is low, no pulse starts, and a pulse that is running ends one clock later. `count` keeps following the encoder, and the reference still reloads at each trigger point.
- R8: A one-clock `cnt_clr` sets `count` and the reference to zero, ends any pulse, and leaves `trig_n` high from the next clock on.
- R9: A phase change applied before clock edge k appears on `count` after edge k+2 and not before.
- R10: Interval detection works across the wrap: 16 steps down from zero (with `STEP` = 16) give 0xFFFFF0 and fire a pulse.
- R11: After `rst_n` is asserted, `count` = 0, `trig_n` = 1, `phase_err` = 0 and `miss_cnt` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for the whole block |
| enc_a | input | 1 | Encoder phase A, single-ended, asynchronous |
| enc_b | input | 1 | Encoder phase B, single-ended, asynchronous |
| en | input | 1 | Active-high pulse enable |
| cnt_clr | input | 1 | Active-high clear of the position and the reference |
| trig_n | output | 1 | Active-low trigger pulse |
| count | output | CNT_W | Current position count |
| phase_err | output | 1 | Sticky flag for an illegal step with both phases changing |
| miss_cnt | output | MISS_W | Saturating count of trigger points that fell inside a running pulse |

## Verification
Several internal faults show on `count` within three clocks of the phase edge that exposes them: a wrong decoder base phase or a bad direction term gives a count off by one or moving the wrong way. A stale or mis-reloaded reference shows only at the next interval boundary. There it appears as a pulse that is missing, early or late, so the bench counts steps up to the exact boundary in both directions and across the wrap. Faults in the pulse timer or in the missed-event logic show as a wrong low-time on `trig_n` or a wrong `miss_cnt` once that pulse ends, which takes up to `PULSE_CLKS` clocks.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
    // Per-clock result of the phase decoder
    typedef struct packed {
        logic step;  // one legal transition seen
        logic up;    // direction of that transition
        logic bad;   // both phases changed together
    } qenc_move_t;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= din;
            else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ph,     // {a, b}, already synchronised
    output qenc_move_t mv
);
    logic [1:0] prev_d, prev_q;
    logic [1:0] diff;

    always_comb begin
        diff    = ph ^ prev_q;
        prev_d  = ph;
        mv.step = (diff == 2'b01) || (diff == 2'b10);
        mv.bad  = (diff == 2'b11);
        // forward order 00,01,11,10: old A differs from new B
        mv.up   = prev_q[1] ^ ph[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b00;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/qenc_pulse.sv
module qenc_pulse #(
    parameter int PULSE_CLKS = 2500,
    parameter int MISS_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              en,
    input  logic              clr,
    output logic              active,
    output logic [MISS_W-1:0] miss
);
    localparam int LW = $clog2(PULSE_CLKS + 1);

    typedef struct packed {
        logic              act;
        logic [LW-1:0]     left;
        logic [MISS_W-1:0] miss;
    } pstate_t;

    pstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.act) begin
            if (st_q.left == '0) st_d.act  = 1'b0;
            else                 st_d.left = st_q.left - 1'b1;
        end
        if (hit && en) begin
            if (st_q.act) begin
                if (st_q.miss != '1) st_d.miss = st_q.miss + 1'b1;
            end else begin
                st_d.act  = 1'b1;
                st_d.left = LW'(PULSE_CLKS - 1);
            end
        end
        if (!en || clr) begin
            st_d.act  = 1'b0;
            st_d.left = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.act;
    assign miss   = st_q.miss;
endmodule

// File: rtl/qenc_step_trigger.sv
module qenc_step_trigger
    import qenc_pkg::*;
#(
    parameter int CNT_W      = 24,
    parameter int STEP       = 50,
    parameter int PULSE_CLKS = 2500,
    parameter int MISS_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              en,
    input  logic              cnt_clr,
    output logic              trig_n,
    output logic [CNT_W-1:0]  count,
    output logic              phase_err,
    output logic [MISS_W-1:0] miss_cnt
);
    localparam logic signed [CNT_W-1:0] STEP_POS = CNT_W'(STEP);
    localparam logic signed [CNT_W-1:0] STEP_NEG = -STEP_POS;

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] ref_pt;
        logic             err;
    } tstate_t;

    logic [1:0]              ph_sync;
    qenc_move_t              dec_mv;
    logic                    dec_bad;
    logic                    hit;
    logic                    pulse_on;
    logic signed [CNT_W-1:0] travel;
    tstate_t                 st_d, st_q;

    qenc_sync #(.W(2), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({enc_a, enc_b}),
        .dout (ph_sync)
    );

    qenc_decode u_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .ph   (ph_sync),
        .mv   (dec_mv)
    );

    assign dec_bad = dec_mv.bad;

    always_comb begin
        st_d   = st_q;
        travel = st_q.pos - st_q.ref_pt;
        hit    = (travel >= STEP_POS) || (travel <= STEP_NEG);
        if (hit)
            st_d.ref_pt = st_q.pos;
        if (dec_mv.step)
            st_d.pos = dec_mv.up ? st_q.pos + 1'b1 : st_q.pos - 1'b1;
        if (dec_mv.bad)
            st_d.err = 1'b1;
        if (cnt_clr) begin
            st_d.pos    = '0;
            st_d.ref_pt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    qenc_pulse #(.PULSE_CLKS(PULSE_CLKS), .MISS_W(MISS_W)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit && !cnt_clr),
        .en    (en),
        .clr   (cnt_clr),
        .active(pulse_on),
        .miss  (miss_cnt)
    );

    assign trig_n    = !pulse_on;
    assign count     = st_q.pos;
    assign phase_err = st_q.err;
endmodule

// File: rtl/qenc_step_trigger_chk.sv
module qenc_step_trigger_chk #(
    parameter int CNT_W      = 24,
    parameter int PULSE_CLKS = 2500,
    parameter int MISS_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              cnt_clr,
    input logic              trig_n,
    input logic [CNT_W-1:0]  count,
    input logic              phase_err,
    input logic [MISS_W-1:0] miss_cnt,
    input logic              bad
);
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (count == $past(count) || count == $past(count) + 1'b1
                      || count == $past(count) - 1'b1)); // R1

    AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bad && !cnt_clr) |=> (count == $past(count) && phase_err)); // R2

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        phase_err |=> phase_err); // R2

    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(trig_n) && en && !cnt_clr && (PULSE_CLKS > 1)) |=> !trig_n); // R5

    AST_MISS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_cnt == '1) |=> (miss_cnt == '1)); // R6

    AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> trig_n); // R7

    AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (count == '0 && trig_n)); // R8
endmodule

bind qenc_step_trigger qenc_step_trigger_chk #(
    .CNT_W(CNT_W), .PULSE_CLKS(PULSE_CLKS), .MISS_W(MISS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cnt_clr  (cnt_clr),
    .trig_n   (trig_n),
    .count    (count),
    .phase_err(phase_err),
    .miss_cnt (miss_cnt),
    .bad      (dec_bad)
);

// File: tb/test_qenc_step_trigger.sv
module test_qenc_step_trigger;
    localparam int CNT_W = 24;
    localparam int STEP  = 16;
    localparam int PW    = 100;
    localparam int MW    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_a = 1'b0, enc_b = 1'b0, en = 1'b1, cnt_clr = 1'b0;
    logic trig_n, phase_err;
    logic [CNT_W-1:0] count;
    logic [MW-1:0] miss_cnt;

    always #2 clk = ~clk; // 250 MHz

    qenc_step_trigger #(.CNT_W(CNT_W), .STEP(STEP), .PULSE_CLKS(PW), .MISS_W(MW))
    i_qenc_step_trigger (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .en(en),
        .cnt_clr(cnt_clr), .trig_n(trig_n), .count(count),
        .phase_err(phase_err), .miss_cnt(miss_cnt)
    );

    int n_chk = 0, n_bad = 0;
    int pulses = 0, last_w = 0, run = 0;
    logic prev_t = 1'b1;
    logic [1:0] idx = 2'd0;
    logic [CNT_W-1:0] exp_cnt = '0;
    bit done = 0;

    // {a, b, err, count}
    localparam logic [26:0] VEC [13] = '{
        {2'b01, 1'b0, 24'd1},        {2'b11, 1'b0, 24'd2},
        {2'b10, 1'b0, 24'd3},        {2'b00, 1'b0, 24'd4},
        {2'b10, 1'b0, 24'd3},        {2'b11, 1'b0, 24'd2},
        {2'b01, 1'b0, 24'd1},        {2'b00, 1'b0, 24'd0},
        {2'b10, 1'b0, 24'hFFFFFF},   {2'b00, 1'b0, 24'd0},
        {2'b11, 1'b1, 24'd0},        {2'b01, 1'b1, 24'hFFFFFF},
        {2'b00, 1'b1, 24'hFFFFFE}
    };

    always @(negedge clk) begin
        if (!trig_n) run <= run + 1;
        else if (!prev_t) begin
            last_w <= run;
            pulses <= pulses + 1;
            run    <= 0;
        end
        prev_t <= trig_n;
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic move(input bit up, input int n);
        for (int i = 0; i < n; i++) begin
            idx = up ? idx + 2'd1 : idx - 2'd1;
            enc_a = idx[1];
            enc_b = idx[1] ^ idx[0];
            exp_cnt = up ? exp_cnt + 1'b1 : exp_cnt - 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_cnt();
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        exp_cnt = '0;
    endtask

    initial begin
        int p0;
        wait_clks(3);
        check("R11 count", count, 0);
        check("R11 trig_n", trig_n, 1);
        check("R11 err", phase_err, 0);
        check("R11 miss", miss_cnt, 0);
        rst_n = 1'b1;
        wait_clks(2);

        // R1 R2 R3: table of phase steps
        for (int v = 0; v < 13; v++) begin
            {enc_a, enc_b} = VEC[v][26:25];
            wait_clks(4);
            check("R1/R2/R3 count", count, VEC[v][23:0]);
            check("R2 err", phase_err, VEC[v][24]);
        end

        rst_n = 1'b0;
        wait_clks(2);
        check("R11 err cleared", phase_err, 0);
        check("R11 count cleared", count, 0);
        rst_n = 1'b1;
        idx = 2'd0; exp_cnt = '0;
        wait_clks(2);

        // R4 R5 forward interval
        p0 = pulses;
        move(1, 15); wait_clks(8);
        check("R4 no early pulse", pulses, p0);
        move(1, 1); wait_clks(110);
        check("R4 pulse up", pulses, p0 + 1);
        check("R5 width", last_w, PW);
        check("R1 count", count, exp_cnt);

        // R4 reverse
        move(0, 16); wait_clks(110);
        check("R4 pulse down", pulses, p0 + 2);
        check("R1 count down", count, exp_cnt);

        // R6 missed and saturation
        for (int r = 0; r < 4; r++) begin
            p0 = pulses;
            move(1, 32); wait_clks(110);
            check("R6 one pulse", pulses, p0 + 1);
            check("R6 not stretched", last_w, PW);
            check("R6 miss", miss_cnt, (r < 3) ? r + 1 : 3);
        end

        // R7 enable gating
        p0 = pulses;
        en = 1'b0;
        move(1, 16); wait_clks(110);
        check("R7 no pulse", pulses, p0);
        check("R7 counting", count, exp_cnt);
        en = 1'b1;
        move(1, 15); wait_clks(8);
        check("R7 ref reloaded", pulses, p0);
        move(1, 1); wait_clks(110);
        check("R7 pulse after", pulses, p0 + 1);
        move(1, 16); wait_clks(10);
        check("R7 pulse running", trig_n, 0);
        en = 1'b0; wait_clks(3);
        check("R7 abort", trig_n, 1);
        check("R7 short", last_w < PW, 1);
        en = 1'b1;

        // R8 clear
        move(1, 16); wait_clks(2);
        check("R8 pulse running", trig_n, 0);
        clear_cnt(); wait_clks(1);
        check("R8 trig high", trig_n, 1);
        check("R8 count zero", count, 0);
        p0 = pulses;
        move(1, 15); wait_clks(8);
        check("R8 ref zero", pulses, p0);
        move(1, 1); wait_clks(110);
        check("R8 pulse at 16", pulses, p0 + 1);

        // R10 wrap
        clear_cnt(); wait_clks(2);
        p0 = pulses;
        move(0, 15); wait_clks(8);
        check("R10 no early", pulses, p0);
        move(0, 1); wait_clks(110);
        check("R10 count", count, 24'hFFFFF0);
        check("R10 pulse", pulses, p0 + 1);

        // R9 latency
        idx = idx + 2'd1;
        enc_a = idx[1]; enc_b = idx[1] ^ idx[0];
        wait_clks(2);
        check("R9 not yet", count, 24'hFFFFF0);
        wait_clks(1);
        check("R9 updated", count, 24'hFFFFF1);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule